// File: doc/BRIEF.md
# Per-Peer Coalescing Write Scheduler

The block sits in front of an outgoing link and turns a stream of small, unordered write fragments into whole flits of `FLIT_BYTES` bytes (128 by default). Each fragment names a destination peer, a row tag and an offset within the row. It carries flit-wide data with per-byte enables and a flag that marks it as low priority. Every peer has its own bank of `ENTRIES` slots. A fragment whose (tag, offset) matches a live slot in its peer's bank merges into that slot. Any other fragment opens a fresh slot.

A slot is ready to send when all of its byte-valid bits are set, or when its age reaches the programmable limit `cfg_timeout`. The second case keeps partial rows from waiting forever. Among ready slots the scheduler applies a fixed order: normal traffic before low-priority traffic, full slots before timed-out partial slots, and within a bank the smallest row tag first. Banks that tie on that rank are served round-robin, starting after the peer served last. The chosen slot is copied to the output register and freed. Each emitted flit carries its byte mask so the far side can apply partial flits.

The control is a two-state machine. IDLE waits for the arbiter. The LATCH transition (IDLE to EMIT) fires on a grant, captures the winner and frees its slot. EMIT presents the flit and stays there (HOLD) while `out_ready` is low. The RELEASE transition (EMIT to IDLE) fires on `out_ready`. Arbitration resumes in the following cycle.

Top module: `frag_coalesce_sched`

## Requirements
- R1: While and right after reset, `out_valid` is 0 and `in_ready` is 1 (all slots free).
- R2: Fragments with the same peer, tag and offset merge into one slot. The mask becomes the OR of their enables, and a later fragment overwrites the bytes it enables.
- R3: A slot whose mask is all ones is emitted without waiting for the timeout, with `out_mask` all ones.
- R4: A partial slot is not emitted before `cfg_timeout` cycles have passed since it was opened. After that it is emitted with its mask, and bytes never written read as zero.
- R5: When every slot of a peer's bank is in use, `in_ready` is 0 for a fragment to that peer with a new key. It stays 1 for a fragment that matches a live slot and for fragments to other peers.
- R6: A ready normal slot is always granted before any ready low-priority slot (`in_lowpri`=1).
- R7: Within a priority class, a full slot is granted before a timed-out partial slot.
- R8: Among slots of one bank with equal rank, the smallest row tag is granted first.
- R9: Banks whose best ready slot has equal rank are served round-robin in ascending peer order, starting at the peer after the last one served.
- R10: Each flit carries the peer, tag, offset and priority flag of the fragments that built it.
- R11: While `out_valid` is 1 and `out_ready` is 0, all flit outputs stay unchanged. After a handshake, `out_valid` is 0 for one cycle.
- R12: A fragment with all byte enables clear is accepted and produces no flit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_timeout | input | AGE_W | Age in cycles at which a partial slot becomes ready |
| in_valid | input | 1 | Fragment present |
| in_ready | output | 1 | Fragment can be taken this cycle |
| in_peer | input | PEER_W | Destination peer |
| in_tag | input | TAG_W | Row tag |
| in_off | input | OFF_W | Offset within the row |
| in_lowpri | input | 1 | Low-priority (metadata) fragment |
| in_data | input | FLIT_BYTES*8 | Fragment data, flit-aligned |
| in_be | input | FLIT_BYTES | Byte enables |
| out_valid | output | 1 | Flit present |
| out_ready | input | 1 | Link accepts the flit |
| out_peer | output | PEER_W | Destination peer of the flit |
| out_tag | output | TAG_W | Row tag of the flit |
| out_off | output | OFF_W | Row offset of the flit |
| out_lowpri | output | 1 | Priority flag of the flit |
| out_data | output | FLIT_BYTES*8 | Flit data |
| out_mask | output | FLIT_BYTES | Byte-valid mask of the flit |

## Verification
The bench stalls the link behind a blocker flit so that several slots are ready at once. It then checks the grant order across priority class, fullness, row tag and peer rotation. A design with the rank bits swapped, the tag comparison reversed or the rotation pointer stuck would emit the flits in a different order from the scoreboard. It overlaps two fragments to show that the later bytes win and that the mask completes the row; a design that dropped the merge would emit two partial flits or the stale bytes. It also fills a bank to expose back-pressure that ignored hits or leaked into other peers, counts cycles to catch a partial slot that leaves early, and sends an empty fragment that must never surface.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    // Grant rank: {low-priority, partial}; smaller value wins.
    typedef logic [1:0] fcs_rank_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } fcs_state_e;

endpackage

// File: rtl/fcs_bank.sv
module fcs_bank
    import fcs_pkg::*;
#(
    parameter int ENTRIES    = 4,
    parameter int TAG_W      = 8,
    parameter int OFF_W      = 4,
    parameter int FLIT_BYTES = 128,
    parameter int AGE_W      = 8,
    localparam int DATA_W    = FLIT_BYTES * 8,
    localparam int SLOT_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [TAG_W-1:0]      wr_tag,
    input  logic [OFF_W-1:0]      wr_off,
    input  logic                  wr_low,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [FLIT_BYTES-1:0] wr_be,
    input  logic [AGE_W-1:0]      cfg_timeout,
    input  logic                  pop_en,
    output logic                  can_accept,
    output logic                  best_valid,
    output fcs_rank_t             best_rank,
    output logic [TAG_W-1:0]      best_tag,
    output logic [OFF_W-1:0]      best_off,
    output logic                  best_low,
    output logic [DATA_W-1:0]     best_data,
    output logic [FLIT_BYTES-1:0] best_mask
);

    logic [ENTRIES-1:0]    vld_q;
    logic [ENTRIES-1:0]    low_q;
    logic [AGE_W-1:0]      age_q  [ENTRIES];
    logic [TAG_W-1:0]      tag_q  [ENTRIES];
    logic [OFF_W-1:0]      off_q  [ENTRIES];
    logic [FLIT_BYTES-1:0] mask_q [ENTRIES];
    logic [DATA_W-1:0]     data_q [ENTRIES];

    logic [ENTRIES-1:0]    ready_vec;
    fcs_rank_t             rank_vec [ENTRIES];
    logic [SLOT_W-1:0]     best_slot;
    logic [SLOT_W-1:0]     hit_idx, free_idx;
    logic                  hit_any, free_any;

    // Readiness and rank of every slot.
    always_comb begin
        for (int s = 0; s < ENTRIES; s++) begin
            ready_vec[s] = vld_q[s] && ((&mask_q[s]) || (age_q[s] >= cfg_timeout));
            rank_vec[s]  = {low_q[s], ~(&mask_q[s])};
        end
    end

    // Best ready slot: lowest rank, then smallest tag, then lowest slot.
    always_comb begin
        logic [TAG_W-1:0] tag_v;
        best_valid = 1'b0;
        best_slot  = '0;
        best_rank  = 2'b11;
        tag_v      = '1;
        for (int s = 0; s < ENTRIES; s++) begin
            if (ready_vec[s] && (!best_valid || (rank_vec[s] < best_rank) ||
                                 ((rank_vec[s] == best_rank) && (tag_q[s] < tag_v)))) begin
                best_valid = 1'b1;
                best_slot  = SLOT_W'(s);
                best_rank  = rank_vec[s];
                tag_v      = tag_q[s];
            end
        end
    end

    assign best_tag  = tag_q[best_slot];
    assign best_off  = off_q[best_slot];
    assign best_low  = low_q[best_slot];
    assign best_data = data_q[best_slot];
    assign best_mask = mask_q[best_slot];

    // Key lookup; a slot leaving this cycle cannot take a merge.
    always_comb begin
        hit_any  = 1'b0;
        free_any = 1'b0;
        hit_idx  = '0;
        free_idx = '0;
        for (int s = ENTRIES - 1; s >= 0; s--) begin
            if (vld_q[s] && (tag_q[s] == wr_tag) && (off_q[s] == wr_off) &&
                !(pop_en && (best_slot == SLOT_W'(s)))) begin
                hit_any = 1'b1;
                hit_idx = SLOT_W'(s);
            end
            if (!vld_q[s]) begin
                free_any = 1'b1;
                free_idx = SLOT_W'(s);
            end
        end
    end

    assign can_accept = hit_any || free_any;

    // Slot occupancy and age.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int s = 0; s < ENTRIES; s++) age_q[s] <= '0;
        end else begin
            for (int s = 0; s < ENTRIES; s++) begin
                if (vld_q[s] && (age_q[s] != '1)) age_q[s] <= age_q[s] + 1'b1;
            end
            if (pop_en) vld_q[best_slot] <= 1'b0;
            if (wr_en && !hit_any) begin
                vld_q[free_idx] <= 1'b1;
                age_q[free_idx] <= '0;
            end
        end
    end

    // Slot payload: merge into a hit, or open a fresh slot.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            if (hit_any) begin
                mask_q[hit_idx] <= mask_q[hit_idx] | wr_be;
                for (int k = 0; k < FLIT_BYTES; k++) begin
                    if (wr_be[k]) data_q[hit_idx][8*k +: 8] <= wr_data[8*k +: 8];
                end
            end else begin
                tag_q[free_idx]  <= wr_tag;
                off_q[free_idx]  <= wr_off;
                low_q[free_idx]  <= wr_low;
                mask_q[free_idx] <= wr_be;
                for (int k = 0; k < FLIT_BYTES; k++) begin
                    data_q[free_idx][8*k +: 8] <= wr_be[k] ? wr_data[8*k +: 8] : 8'h00;
                end
            end
        end
    end

endmodule

// File: rtl/fcs_arb.sv
module fcs_arb
    import fcs_pkg::*;
#(
    parameter int NUM_PEERS = 4,
    localparam int PEER_W   = (NUM_PEERS > 1) ? $clog2(NUM_PEERS) : 1
) (
    input  logic [NUM_PEERS-1:0]            req,
    input  fcs_rank_t [NUM_PEERS-1:0]       rank,
    input  logic [PEER_W-1:0]               rr_ptr,
    output logic                            grant_valid,
    output logic [PEER_W-1:0]               grant_peer
);

    fcs_rank_t top_rank;

    always_comb begin
        top_rank = 2'b11;
        for (int p = 0; p < NUM_PEERS; p++) begin
            if (req[p] && (rank[p] < top_rank)) top_rank = rank[p];
        end
    end

    // Rotate from rr_ptr; first bank holding the top rank wins.
    always_comb begin
        grant_valid = 1'b0;
        grant_peer  = '0;
        for (int i = 0; i < NUM_PEERS; i++) begin
            int idx;
            idx = int'(rr_ptr) + i;
            if (idx >= NUM_PEERS) idx = idx - NUM_PEERS;
            if (!grant_valid && req[idx] && (rank[idx] == top_rank)) begin
                grant_valid = 1'b1;
                grant_peer  = PEER_W'(idx);
            end
        end
    end

endmodule

// File: rtl/frag_coalesce_sched.sv
module frag_coalesce_sched
    import fcs_pkg::*;
#(
    parameter int NUM_PEERS  = 4,
    parameter int ENTRIES    = 4,
    parameter int TAG_W      = 8,
    parameter int OFF_W      = 4,
    parameter int FLIT_BYTES = 128,
    parameter int AGE_W      = 8,
    localparam int PEER_W    = (NUM_PEERS > 1) ? $clog2(NUM_PEERS) : 1,
    localparam int DATA_W    = FLIT_BYTES * 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [AGE_W-1:0]      cfg_timeout,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [PEER_W-1:0]     in_peer,
    input  logic [TAG_W-1:0]      in_tag,
    input  logic [OFF_W-1:0]      in_off,
    input  logic                  in_lowpri,
    input  logic [DATA_W-1:0]     in_data,
    input  logic [FLIT_BYTES-1:0] in_be,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [PEER_W-1:0]     out_peer,
    output logic [TAG_W-1:0]      out_tag,
    output logic [OFF_W-1:0]      out_off,
    output logic                  out_lowpri,
    output logic [DATA_W-1:0]     out_data,
    output logic [FLIT_BYTES-1:0] out_mask
);

    logic [NUM_PEERS-1:0]      bank_ok;
    logic [NUM_PEERS-1:0]      bank_req;
    logic [NUM_PEERS-1:0]      bank_pop;
    fcs_rank_t [NUM_PEERS-1:0] bank_rank;
    logic [TAG_W-1:0]          bank_tag  [NUM_PEERS];
    logic [OFF_W-1:0]          bank_off  [NUM_PEERS];
    logic [NUM_PEERS-1:0]      bank_low;
    logic [DATA_W-1:0]         bank_data [NUM_PEERS];
    logic [FLIT_BYTES-1:0]     bank_mask [NUM_PEERS];

    logic                      grant_valid;
    logic [PEER_W-1:0]         grant_peer;
    logic [PEER_W-1:0]         rr_q;
    logic                      take;
    logic                      peer_ok;

    fcs_state_e                state_q, state_d;

    assign peer_ok  = (int'(in_peer) < NUM_PEERS);
    assign in_ready = peer_ok && bank_ok[in_peer];

    for (genvar b = 0; b < NUM_PEERS; b++) begin : g_bank
        logic wr_en;
        assign wr_en       = in_valid && in_ready && (in_peer == PEER_W'(b)) && (|in_be);
        assign bank_pop[b] = take && (grant_peer == PEER_W'(b));

        fcs_bank #(
            .ENTRIES    (ENTRIES),
            .TAG_W      (TAG_W),
            .OFF_W      (OFF_W),
            .FLIT_BYTES (FLIT_BYTES),
            .AGE_W      (AGE_W)
        ) u_bank (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_en       (wr_en),
            .wr_tag      (in_tag),
            .wr_off      (in_off),
            .wr_low      (in_lowpri),
            .wr_data     (in_data),
            .wr_be       (in_be),
            .cfg_timeout (cfg_timeout),
            .pop_en      (bank_pop[b]),
            .can_accept  (bank_ok[b]),
            .best_valid  (bank_req[b]),
            .best_rank   (bank_rank[b]),
            .best_tag    (bank_tag[b]),
            .best_off    (bank_off[b]),
            .best_low    (bank_low[b]),
            .best_data   (bank_data[b]),
            .best_mask   (bank_mask[b])
        );
    end

    fcs_arb #(
        .NUM_PEERS (NUM_PEERS)
    ) u_arb (
        .req         (bank_req),
        .rank        (bank_rank),
        .rr_ptr      (rr_q),
        .grant_valid (grant_valid),
        .grant_peer  (grant_peer)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: LATCH (IDLE->EMIT), HOLD (EMIT), RELEASE (EMIT->IDLE).
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (grant_valid) state_d = ST_EMIT;
            ST_EMIT: if (out_ready)   state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // Outputs of the state machine.
    always_comb begin
        out_valid = (state_q == ST_EMIT);
        take      = (state_q == ST_IDLE) && grant_valid;
    end

    // Flit register and rotation pointer, loaded on LATCH.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rr_q       <= '0;
            out_peer   <= '0;
            out_tag    <= '0;
            out_off    <= '0;
            out_lowpri <= 1'b0;
            out_data   <= '0;
            out_mask   <= '0;
        end else if (take) begin
            rr_q       <= (int'(grant_peer) == NUM_PEERS - 1) ? '0 : grant_peer + 1'b1;
            out_peer   <= grant_peer;
            out_tag    <= bank_tag[grant_peer];
            out_off    <= bank_off[grant_peer];
            out_lowpri <= bank_low[grant_peer];
            out_data   <= bank_data[grant_peer];
            out_mask   <= bank_mask[grant_peer];
        end
    end

endmodule

// File: rtl/fcs_chk.sv
module fcs_chk #(
    parameter int NUM_PEERS  = 4,
    parameter int PEER_W     = 2,
    parameter int TAG_W      = 8,
    parameter int OFF_W      = 4,
    parameter int FLIT_BYTES = 128
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    out_valid,
    input logic                    out_ready,
    input logic [PEER_W-1:0]       out_peer,
    input logic [TAG_W-1:0]        out_tag,
    input logic [OFF_W-1:0]        out_off,
    input logic                    out_lowpri,
    input logic [FLIT_BYTES*8-1:0] out_data,
    input logic [FLIT_BYTES-1:0]   out_mask
);

    // R11
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_peer) && $stable(out_tag) &&
                                       $stable(out_off) && $stable(out_lowpri) &&
                                       $stable(out_data) && $stable(out_mask)));

    // R11
    out_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> !out_valid);

    // R12
    out_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_mask != '0));

    // R10
    out_peer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_peer) < NUM_PEERS));

endmodule

bind frag_coalesce_sched fcs_chk #(
    .NUM_PEERS  (NUM_PEERS),
    .PEER_W     (PEER_W),
    .TAG_W      (TAG_W),
    .OFF_W      (OFF_W),
    .FLIT_BYTES (FLIT_BYTES)
) u_fcs_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_peer   (out_peer),
    .out_tag    (out_tag),
    .out_off    (out_off),
    .out_lowpri (out_lowpri),
    .out_data   (out_data),
    .out_mask   (out_mask)
);

// File: tb/test_frag_coalesce_sched.sv
`timescale 1ns/1ps
module test_frag_coalesce_sched;

    localparam int FB = 128;
    localparam int DW = FB * 8;

    typedef struct packed {
        logic [1:0]    peer;
        logic [7:0]    tag;
        logic [3:0]    off;
        logic          low;
        logic [DW-1:0] data;
        logic [FB-1:0] mask;
    } flit_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    cfg_timeout = 8'd200;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [1:0]    in_peer = '0;
    logic [7:0]    in_tag = '0;
    logic [3:0]    in_off = '0;
    logic          in_lowpri = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic [FB-1:0] in_be = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [1:0]    out_peer;
    logic [7:0]    out_tag;
    logic [3:0]    out_off;
    logic          out_lowpri;
    logic [DW-1:0] out_data;
    logic [FB-1:0] out_mask;

    int checks = 0;
    int errors = 0;
    flit_t exp_q[$];
    string req_q[$];

    always #4 clk = ~clk;

    frag_coalesce_sched i_frag_coalesce_sched (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_timeout (cfg_timeout),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_peer     (in_peer),
        .in_tag      (in_tag),
        .in_off      (in_off),
        .in_lowpri   (in_lowpri),
        .in_data     (in_data),
        .in_be       (in_be),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_peer    (out_peer),
        .out_tag     (out_tag),
        .out_off     (out_off),
        .out_lowpri  (out_lowpri),
        .out_data    (out_data),
        .out_mask    (out_mask)
    );

    function automatic logic [DW-1:0] pat(input int seed);
        for (int k = 0; k < FB; k++) pat[8*k +: 8] = 8'(seed * 7 + k * 3 + 1);
    endfunction

    function automatic logic [FB-1:0] lo_be(input int n);
        for (int k = 0; k < FB; k++) lo_be[k] = (k < n);
    endfunction

    function automatic logic [DW-1:0] keep(input logic [DW-1:0] d, input logic [FB-1:0] be);
        for (int k = 0; k < FB; k++) keep[8*k +: 8] = be[k] ? d[8*k +: 8] : 8'h00;
    endfunction

    task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic expect_flit(input int peer, input int tag, input int off, input bit low,
                               input logic [DW-1:0] d, input logic [FB-1:0] m, input string req);
        flit_t f;
        f.peer = 2'(peer); f.tag = 8'(tag); f.off = 4'(off); f.low = low; f.data = d; f.mask = m;
        exp_q.push_back(f);
        req_q.push_back(req);
    endtask

    task automatic send(input int peer, input int tag, input int off, input bit low,
                        input logic [DW-1:0] d, input logic [FB-1:0] be);
        @(posedge clk); #2;
        in_valid = 1'b1; in_peer = 2'(peer); in_tag = 8'(tag); in_off = 4'(off);
        in_lowpri = low; in_data = d; in_be = be;
        forever begin
            @(negedge clk);
            if (in_ready) break;
        end
        @(posedge clk); #2;
        in_valid = 1'b0;
    endtask

    task automatic set_ready(input bit r);
        @(posedge clk); #2;
        out_ready = r;
    endtask

    task automatic set_timeout(input int t);
        @(posedge clk); #2;
        cfg_timeout = 8'(t);
    endtask

    task automatic drain(input string req);
        int n = 0;
        while (exp_q.size() > 0 && n < 500) begin
            @(negedge clk);
            n++;
        end
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, req, "flits still expected", exp_q.size(), 0);
    endtask

    // Monitor: compare each accepted flit against the scoreboard.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && out_valid && out_ready) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R10 unexpected flit: actual peer %0d tag %0d expected none",
                             out_peer, out_tag);
                end else begin
                    flit_t e;
                    string r;
                    e = exp_q.pop_front();
                    r = req_q.pop_front();
                    if (out_peer !== e.peer || out_tag !== e.tag || out_off !== e.off ||
                        out_lowpri !== e.low || out_mask !== e.mask || out_data !== e.data) begin
                        errors++;
                        $display("FAIL %s flit: actual peer %0d tag %0d off %0d low %0b mask %h data_ok %0b expected peer %0d tag %0d off %0d low %0b mask %h",
                                 r, out_peer, out_tag, out_off, out_lowpri, out_mask,
                                 out_data === e.data, e.peer, e.tag, e.off, e.low, e.mask);
                    end
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit quiet;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
        @(posedge clk); #2 rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);

        // R12: empty fragment leaves no trace, even with timeout 0
        set_timeout(0);
        send(0, 99, 0, 1'b0, pat(9), '0);
        quiet = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (out_valid) quiet = 1'b0;
        end
        check(quiet, "R12", "out_valid after empty fragment", int'(!quiet), 0);
        set_timeout(200);

        // R2/R3/R10: overlapping fragments complete a row, later bytes win
        expect_flit(1, 4, 2, 1'b0, keep(pat(1), lo_be(64)) | keep(pat(2), ~lo_be(64)), '1, "R2");
        send(1, 4, 2, 1'b0, pat(1), lo_be(96));
        send(1, 4, 2, 1'b0, pat(2), ~lo_be(64));
        drain("R3");

        // R4: partial low-priority slot waits for the timeout
        set_timeout(6);
        expect_flit(2, 9, 1, 1'b1, keep(pat(3), lo_be(16)), lo_be(16), "R4");
        send(2, 9, 1, 1'b1, pat(3), lo_be(16));
        quiet = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (out_valid) quiet = 1'b0;
        end
        check(quiet, "R4", "early emit of partial slot", int'(!quiet), 0);
        drain("R4");

        // R5: full bank back-pressures new keys only
        set_timeout(200);
        for (int i = 0; i < 4; i++) send(0, 10 + i, 0, 1'b0, pat(10 + i), lo_be(8));
        @(posedge clk); #2;
        in_peer = 2'd0; in_tag = 8'd14; in_off = 4'd0;
        @(negedge clk);
        check(in_ready == 1'b0, "R5", "in_ready new key full bank", int'(in_ready), 0);
        @(posedge clk); #2 in_tag = 8'd11;
        @(negedge clk);
        check(in_ready == 1'b1, "R5", "in_ready hit in full bank", int'(in_ready), 1);
        @(posedge clk); #2 in_peer = 2'd3; in_tag = 8'd14;
        @(negedge clk);
        check(in_ready == 1'b1, "R5", "in_ready other peer", int'(in_ready), 1);
        // R8: timed-out partials of one bank leave in tag order
        for (int i = 0; i < 4; i++)
            expect_flit(0, 10 + i, 0, 1'b0, keep(pat(10 + i), lo_be(8)), lo_be(8), "R8");
        set_timeout(0);
        drain("R8");
        set_timeout(200);

        // R6/R8/R11: class first, then smallest tag
        set_ready(1'b0);
        expect_flit(0, 50, 0, 1'b0, pat(50), '1, "R11");
        send(0, 50, 0, 1'b0, pat(50), '1);
        send(1, 1, 0, 1'b1, pat(51), '1);
        send(1, 7, 0, 1'b0, pat(52), '1);
        send(1, 3, 0, 1'b0, pat(53), '1);
        expect_flit(1, 3, 0, 1'b0, pat(53), '1, "R8");
        expect_flit(1, 7, 0, 1'b0, pat(52), '1, "R8");
        expect_flit(1, 1, 0, 1'b1, pat(51), '1, "R6");
        repeat (3) @(negedge clk);
        check(out_valid == 1'b1 && out_tag == 8'd50, "R11", "held flit tag", int'(out_tag), 50);
        set_ready(1'b1);
        drain("R6");

        // R7: full before timed-out partial, despite larger tag
        set_timeout(3);
        set_ready(1'b0);
        expect_flit(0, 60, 0, 1'b0, pat(60), '1, "R7");
        send(0, 60, 0, 1'b0, pat(60), '1);
        send(2, 1, 0, 1'b0, pat(61), lo_be(4));
        send(2, 5, 0, 1'b0, pat(62), '1);
        expect_flit(2, 5, 0, 1'b0, pat(62), '1, "R7");
        expect_flit(2, 1, 0, 1'b0, keep(pat(61), lo_be(4)), lo_be(4), "R7");
        repeat (10) @(negedge clk);
        set_ready(1'b1);
        drain("R7");

        // R9: rotation starts after the last served peer
        set_timeout(200);
        set_ready(1'b0);
        expect_flit(2, 70, 0, 1'b0, pat(70), '1, "R9");
        send(2, 70, 0, 1'b0, pat(70), '1);
        send(1, 5, 0, 1'b0, pat(71), '1);
        send(0, 10, 0, 1'b0, pat(72), '1);
        send(3, 20, 0, 1'b0, pat(73), '1);
        expect_flit(3, 20, 0, 1'b0, pat(73), '1, "R9");
        expect_flit(0, 10, 0, 1'b0, pat(72), '1, "R9");
        expect_flit(1, 5, 0, 1'b0, pat(71), '1, "R9");
        repeat (2) @(negedge clk);
        set_ready(1'b1);
        drain("R9");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule